// File: doc/BRIEF.md
# DMA Destination Access Filter

This block sits between an internal DMA engine and the outbound ports of a chip's memory hub. Each DMA request carries an address and a direction. The block decides whether the request goes to one of the downstream peer ports or whether it is aborted, and it reports a reason code for every abort.

The decision compares the address against a set of relocatable windows, each described by an inclusive base and limit:

- one legacy-interface range;
- a memory window and a prefetchable memory window for the upstream segment;
- a memory window and a prefetchable memory window for each peer port.

Only writes into a peer port's window are forwarded, and only while that port's memory-access enable is set. Reads between peer segments are aborted. Any hit in an upstream window or in the legacy range is aborted, whatever the direction.

Window bounds live in a small register file written through a one-cycle write port. Per-port memory-access enables arrive as a level input and are sampled when a request is accepted. The result is registered and delivered one cycle after acceptance through a valid/ready response channel.

Top module: `dmaf_filter`

## Requirements
- R1: A window matches an address when base <= address <= limit, with both ends inclusive. A window whose limit is below its base never matches.
- R2: A write that matches peer port n, while bit n of `port_mae` is 1, gives `rsp_fwd`=1, `rsp_reason`=0 and `rsp_port`=n.
- R3: A write that matches peer port n, while bit n of `port_mae` is 0, gives `rsp_abort`=1, `rsp_reason`=2 and `rsp_port`=n.
- R4: A read (`req_write`=0) that matches any peer port window gives `rsp_abort`=1, `rsp_reason`=3 and `rsp_port`=n of the matched port.
- R5: An access of either direction that matches the upstream memory or upstream prefetchable window gives `rsp_reason`=1 and `rsp_port`=0. This takes precedence over peer windows.
- R6: An access inside the legacy range gives `rsp_reason`=4 and `rsp_port`=0. This takes precedence over every other window.
- R7: An access that matches no window gives `rsp_reason`=5 and `rsp_port`=0.
- R8: When windows of several peer ports match, the lowest-numbered port decides both the outcome and `rsp_port`.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its decision appears with `rsp_valid`=1 after that edge. `req_ready` equals `!rsp_valid || rsp_ready`. A response that is not taken stays unchanged.
- R10: Register index `cfg_idx` = 2*w + s, where s=0 selects the base and s=1 selects the limit of window w. Window 0 is the legacy range, 1 is upstream memory, 2 is upstream prefetchable, 3+2n is peer n memory, and 4+2n is peer n prefetchable. Indices beyond the last register are ignored. Reset sets every base to all ones and every limit to zero, so every window starts disabled. A request accepted on the same edge as a register write is decided with the values from before that write.
- R11: While `rsp_valid` is 1, exactly one of `rsp_fwd` and `rsp_abort` is 1, and `rsp_fwd` is 1 only when `rsp_reason`=0. Both are 0 while `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_idx | input | IDX_W | Window register index (2*window + bound select) |
| cfg_wdata | input | ADDR_W | Value written to the selected bound |
| port_mae | input | N_PORTS | Memory-access enable per peer port |
| req_valid | input | 1 | DMA request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Destination address |
| rsp_valid | output | 1 | Decision valid |
| rsp_ready | input | 1 | Decision consumed |
| rsp_fwd | output | 1 | Forward strobe |
| rsp_abort | output | 1 | Abort strobe |
| rsp_port | output | PORT_W | Destination or matched peer port |
| rsp_reason | output | 3 | 0 fwd, 1 upstream, 2 disabled, 3 peer read, 4 legacy, 5 unmapped |

## Verification
Two pairs of functions can meet on the same edge.

The first pair is a window register write and the acceptance of a request whose outcome depends on that register. The bench drives a limit update that disables a peer window together with a write to that window. It expects the forward decision made with the old bound, and then an unmapped abort on the following request.

The second pair is the draining of a stalled response and the acceptance of the next request. The bench holds `rsp_ready` low while a second request waits, and checks that `req_ready` is low and the held response is stable. It then raises `rsp_ready` and expects the second request's decision on the very next cycle.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;

   typedef enum logic [2:0] {
      RSN_FWD       = 3'd0,
      RSN_UPSTREAM  = 3'd1,
      RSN_DISABLED  = 3'd2,
      RSN_PEER_READ = 3'd3,
      RSN_LEGACY    = 3'd4,
      RSN_UNMAPPED  = 3'd5
   } reason_e;

   // fixed window slots; peer n occupies WIN_PEER0+2n (mem) and +1 (prefetchable)
   localparam int WIN_LEGACY  = 0;
   localparam int WIN_UP_MEM  = 1;
   localparam int WIN_UP_PMEM = 2;
   localparam int WIN_PEER0   = 3;

   function automatic int win_count(input int n_ports);
      return WIN_PEER0 + 2 * n_ports;
   endfunction

endpackage

// File: rtl/dmaf_win_regs.sv
module dmaf_win_regs
   import dmaf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NW     = 11,
   parameter int IDX_W  = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [IDX_W-1:0]           cfg_idx,
   input  logic [ADDR_W-1:0]          cfg_wdata,
   output logic [NW-1:0][ADDR_W-1:0]  win_base,
   output logic [NW-1:0][ADDR_W-1:0]  win_limit
);

   localparam int NREG = 2 * NW;

   if ((1 << IDX_W) < NREG) begin : g_bad_idx
      $error("dmaf_win_regs: IDX_W too narrow for %0d registers", NREG);
   end

   for (genvar w = 0; w < NW; w++) begin : g_win
      logic sel_base, sel_limit;
      assign sel_base  = cfg_we && (cfg_idx == IDX_W'(2 * w));
      assign sel_limit = cfg_we && (cfg_idx == IDX_W'(2 * w + 1));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            win_base[w]  <= '1;
            win_limit[w] <= '0;
         end else begin
            if (sel_base)  win_base[w]  <= cfg_wdata;
            if (sel_limit) win_limit[w] <= cfg_wdata;
         end
      end
   end

endmodule

// File: rtl/dmaf_win_match.sv
module dmaf_win_match #(
   parameter int ADDR_W       = 32,
   parameter int NW           = 11,
   parameter bit EXPLICIT_ENA = 1'b1
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NW-1:0][ADDR_W-1:0]  win_base,
   input  logic [NW-1:0][ADDR_W-1:0]  win_limit,
   output logic [NW-1:0]              hit
);

   for (genvar w = 0; w < NW; w++) begin : g_cmp
      logic ge_base, le_limit;
      assign ge_base  = (addr >= win_base[w]);
      assign le_limit = (addr <= win_limit[w]);

      if (EXPLICIT_ENA) begin : g_ena
         // separate enable term: keeps the disable rule visible in timing reports
         logic ena;
         assign ena    = (win_limit[w] >= win_base[w]);
         assign hit[w] = ena && ge_base && le_limit;
      end else begin : g_plain
         // limit < base already makes the range empty
         assign hit[w] = ge_base && le_limit;
      end
   end

endmodule

// File: rtl/dmaf_decide.sv
module dmaf_decide
   import dmaf_pkg::*;
#(
   parameter int N_PORTS = 4,
   parameter int NW      = 11,
   parameter int PORT_W  = 2
) (
   input  logic [NW-1:0]       hit,
   input  logic                is_write,
   input  logic [N_PORTS-1:0]  mae,
   output reason_e             reason,
   output logic [PORT_W-1:0]   port
);

   logic [N_PORTS-1:0] peer_hit;

   for (genvar n = 0; n < N_PORTS; n++) begin : g_peer
      assign peer_hit[n] = hit[WIN_PEER0 + 2 * n] | hit[WIN_PEER0 + 2 * n + 1];
   end

   logic              any_peer;
   logic [PORT_W-1:0] peer_sel;
   logic              peer_mae;

   // lowest-numbered hitting port wins: scan from the top, last write stays
   always_comb begin
      any_peer = 1'b0;
      peer_sel = '0;
      peer_mae = 1'b0;
      for (int n = N_PORTS - 1; n >= 0; n--) begin
         if (peer_hit[n]) begin
            any_peer = 1'b1;
            peer_sel = PORT_W'(n);
            peer_mae = mae[n];
         end
      end
   end

   always_comb begin
      reason = RSN_UNMAPPED;
      port   = '0;
      if (hit[WIN_LEGACY]) begin
         reason = RSN_LEGACY;
      end else if (hit[WIN_UP_MEM] || hit[WIN_UP_PMEM]) begin
         reason = RSN_UPSTREAM;
      end else if (any_peer) begin
         port = peer_sel;
         if (!is_write)     reason = RSN_PEER_READ;
         else if (peer_mae) reason = RSN_FWD;
         else               reason = RSN_DISABLED;
      end
   end

endmodule

// File: rtl/dmaf_filter.sv
module dmaf_filter
   import dmaf_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int N_PORTS      = 4,
   parameter bit EXPLICIT_ENA = 1'b1,
   localparam int NW          = win_count(N_PORTS),
   localparam int IDX_W       = $clog2(2 * NW),
   localparam int PORT_W      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [IDX_W-1:0]     cfg_idx,
   input  logic [ADDR_W-1:0]    cfg_wdata,
   input  logic [N_PORTS-1:0]   port_mae,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   output logic                 rsp_valid,
   input  logic                 rsp_ready,
   output logic                 rsp_fwd,
   output logic                 rsp_abort,
   output logic [PORT_W-1:0]    rsp_port,
   output logic [2:0]           rsp_reason
);

   if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_aw
      $error("dmaf_filter: ADDR_W %0d outside 4..64", ADDR_W);
   end
   if (N_PORTS < 1 || N_PORTS > 16) begin : g_bad_np
      $error("dmaf_filter: N_PORTS %0d outside 1..16", N_PORTS);
   end

   logic [NW-1:0][ADDR_W-1:0] win_base;
   logic [NW-1:0][ADDR_W-1:0] win_limit;
   logic [NW-1:0]             hit;
   reason_e                   dec_reason;
   logic [PORT_W-1:0]         dec_port;

   dmaf_win_regs #(
      .ADDR_W (ADDR_W),
      .NW     (NW),
      .IDX_W  (IDX_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .win_base  (win_base),
      .win_limit (win_limit)
   );

   dmaf_win_match #(
      .ADDR_W       (ADDR_W),
      .NW           (NW),
      .EXPLICIT_ENA (EXPLICIT_ENA)
   ) u_match (
      .addr      (req_addr),
      .win_base  (win_base),
      .win_limit (win_limit),
      .hit       (hit)
   );

   dmaf_decide #(
      .N_PORTS (N_PORTS),
      .NW      (NW),
      .PORT_W  (PORT_W)
   ) u_decide (
      .hit      (hit),
      .is_write (req_write),
      .mae      (port_mae),
      .reason   (dec_reason),
      .port     (dec_port)
   );

   logic accept;
   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;

   reason_e rsp_reason_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_reason_q <= RSN_FWD;
         rsp_port     <= '0;
      end else if (accept) begin
         rsp_valid    <= 1'b1;
         rsp_reason_q <= dec_reason;
         rsp_port     <= dec_port;
      end else if (rsp_ready) begin
         rsp_valid    <= 1'b0;
      end
   end

   assign rsp_reason = rsp_reason_q;
   assign rsp_fwd    = rsp_valid && (rsp_reason_q == RSN_FWD);
   assign rsp_abort  = rsp_valid && (rsp_reason_q != RSN_FWD);

endmodule

// File: rtl/dmaf_checker.sv
module dmaf_checker #(
   parameter int ADDR_W  = 32,
   parameter int N_PORTS = 4,
   parameter int IDX_W   = 5,
   parameter int PORT_W  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic [IDX_W-1:0]   cfg_idx,
   input logic [ADDR_W-1:0]  cfg_wdata,
   input logic [N_PORTS-1:0] port_mae,
   input logic               req_valid,
   input logic               req_ready,
   input logic               req_write,
   input logic [ADDR_W-1:0]  req_addr,
   input logic               rsp_valid,
   input logic               rsp_ready,
   input logic               rsp_fwd,
   input logic               rsp_abort,
   input logic [PORT_W-1:0]  rsp_port,
   input logic [2:0]         rsp_reason
);

   // record of the last accepted request, kept by the checker itself
   logic               cap_ok;
   logic               cap_wr;
   logic [N_PORTS-1:0] cap_mae;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_ok  <= 1'b0;
         cap_wr  <= 1'b0;
         cap_mae <= '0;
      end else if (req_valid && req_ready) begin
         cap_ok  <= 1'b1;
         cap_wr  <= req_write;
         cap_mae <= port_mae;
      end
   end

   logic sel_mae;
   assign sel_mae = ((cap_mae >> rsp_port) & N_PORTS'(1)) != '0;

   a_r9_accept_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_reason) && $stable(rsp_port)));

   a_r9_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);

   a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_fwd, rsp_abort}) == 1));

   a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_fwd || rsp_abort));

   a_r11_reason_legal: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_reason <= 3'd5));

   a_r2_fwd_needs_write_and_mae: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fwd && cap_ok) |-> (cap_wr && sel_mae));

   a_r4_read_never_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && cap_ok && !cap_wr) |-> !rsp_fwd);

   a_r7_port_zero_nonpeer: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_reason == 3'd1 || rsp_reason == 3'd4 || rsp_reason == 3'd5))
         |-> (rsp_port == '0));

endmodule

bind dmaf_filter dmaf_checker #(
   .ADDR_W  (ADDR_W),
   .N_PORTS (N_PORTS),
   .IDX_W   (IDX_W),
   .PORT_W  (PORT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_idx    (cfg_idx),
   .cfg_wdata  (cfg_wdata),
   .port_mae   (port_mae),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .rsp_valid  (rsp_valid),
   .rsp_ready  (rsp_ready),
   .rsp_fwd    (rsp_fwd),
   .rsp_abort  (rsp_abort),
   .rsp_port   (rsp_port),
   .rsp_reason (rsp_reason)
);

// File: tb/test_dmaf_filter.sv
`timescale 1ns/1ps
module test_dmaf_filter;

   localparam int AW = 8;
   localparam int NP = 2;
   localparam int NW = 3 + 2 * NP;
   localparam int IW = $clog2(2 * NW);
   localparam int PW = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic [NP-1:0] port_mae = '0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid;
   logic          rsp_ready = 1'b1;
   logic          rsp_fwd, rsp_abort;
   logic [PW-1:0] rsp_port;
   logic [2:0]    rsp_reason;

   always #2 clk = ~clk;

   dmaf_filter #(.ADDR_W(AW), .N_PORTS(NP)) i_dmaf_filter (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .port_mae(port_mae), .req_valid(req_valid),
      .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fwd(rsp_fwd),
      .rsp_abort(rsp_abort), .rsp_port(rsp_port), .rsp_reason(rsp_reason)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // bench model of the window bounds
   logic [AW-1:0] mb [NW];
   logic [AW-1:0] ml [NW];

   function automatic bit mhit(int w, logic [AW-1:0] a);
      return (mb[w] <= a) && (a <= ml[w]);
   endfunction

   function automatic logic [3:0] model(logic [AW-1:0] a, logic wr, logic [NP-1:0] mae);
      if (mhit(0, a)) return {3'd4, 1'b0};
      if (mhit(1, a) || mhit(2, a)) return {3'd1, 1'b0};
      for (int n = 0; n < NP; n++) begin
         if (mhit(3 + 2 * n, a) || mhit(4 + 2 * n, a)) begin
            if (!wr) return {3'd3, PW'(n)};
            if (mae[n]) return {3'd0, PW'(n)};
            return {3'd2, PW'(n)};
         end
      end
      return {3'd5, 1'b0};
   endfunction

   function automatic string rtag(logic [2:0] r);
      case (r)
         3'd0: return "R2";
         3'd1: return "R5";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(string tag, bit ok, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic reg_wr(int idx, logic [AW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_win(int w, logic [AW-1:0] b, logic [AW-1:0] l);
      reg_wr(2 * w, b);
      reg_wr(2 * w + 1, l);
      mb[w] = b; ml[w] = l;
   endtask

   task automatic check_rsp(string tag, logic [2:0] er, logic [PW-1:0] ep);
      chk(tag, rsp_valid == 1'b1, "rsp_valid", int'(rsp_valid), 1);
      chk(tag, rsp_reason == er, "rsp_reason", int'(rsp_reason), int'(er));
      chk(tag, rsp_port == ep, "rsp_port", int'(rsp_port), int'(ep));
      chk("R11", rsp_fwd == (er == 3'd0) && rsp_abort == (er != 3'd0),
          "strobes", int'({rsp_fwd, rsp_abort}), int'({er == 3'd0, er != 3'd0}));
   endtask

   task automatic req(string tag, logic [AW-1:0] a, logic wr, logic [NP-1:0] mae);
      logic [3:0] e;
      e = model(a, wr, mae);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; port_mae = mae; rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp(tag == "" ? rtag(e[3:1]) : tag, e[3:1], e[0]);
   endtask

   task automatic setup_s1();
      set_win(0, 8'hF0, 8'hFF);
      set_win(1, 8'h00, 8'h1F);
      set_win(2, 8'h20, 8'h2F);
      set_win(3, 8'h40, 8'h5F);
      set_win(4, 8'h60, 8'h6F);
      set_win(5, 8'h50, 8'h7F);
      set_win(6, 8'h80, 8'hF7);
   endtask

   task automatic setup_s2();
      set_win(0, 8'h00, 8'h00);
      set_win(1, 8'hC0, 8'hBF);
      set_win(2, 8'hFF, 8'hFF);
      set_win(3, 8'h90, 8'h10);
      set_win(4, 8'h30, 8'h8F);
      set_win(5, 8'hA5, 8'hA5);
      set_win(6, 8'h01, 8'h40);
   endtask

   task automatic sweep();
      for (int m = 0; m < 4; m++)
         for (int a = 0; a < 256; a++)
            for (int w = 0; w < 2; w++)
               req("", AW'(a), w[0], NP'(m));
   endtask

   initial begin
      for (int w = 0; w < NW; w++) begin mb[w] = '1; ml[w] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", rsp_valid == 1'b0, "reset rsp_valid", int'(rsp_valid), 0);
      chk("R9", req_ready == 1'b1, "reset req_ready", int'(req_ready), 1);
      chk("R11", !rsp_fwd && !rsp_abort, "reset strobes", int'({rsp_fwd, rsp_abort}), 0);
      // R10 reset: all windows disabled, so everything is unmapped
      req("R10", 8'h00, 1'b1, 2'b11);
      req("R10", 8'hFF, 1'b1, 2'b11);
      req("R10", 8'h80, 1'b0, 2'b11);

      setup_s1();
      // R1 inclusive bounds
      req("R1", 8'h40, 1'b1, 2'b11);
      req("R1", 8'h3F, 1'b1, 2'b11);
      req("R1", 8'h6F, 1'b1, 2'b11);
      // R8 overlap of peer 0 and peer 1: peer 0 decides
      req("R8", 8'h55, 1'b1, 2'b10);
      chk("R8", rsp_port == 1'b0 && rsp_reason == 3'd2, "lowest port",
          int'({rsp_port, rsp_reason}), 2);
      // R6 legacy beats peer 1 prefetchable
      req("R6", 8'hF3, 1'b1, 2'b11);
      // R10 out-of-range index is ignored
      reg_wr(15, 8'h00);
      reg_wr(14, 8'h00);
      req("R10", 8'h00, 1'b1, 2'b11);
      req("R10", 8'h45, 1'b1, 2'b11);

      // R9 stall and back-to-back acceptance
      @(negedge clk);
      req_valid = 1'b1; req_addr = 8'h44; req_write = 1'b1; port_mae = 2'b01; rsp_ready = 1'b0;
      @(negedge clk);
      req_addr = 8'h30; req_write = 1'b0;
      chk("R9", req_ready == 1'b0, "req_ready while stalled", int'(req_ready), 0);
      repeat (2) @(negedge clk);
      check_rsp("R9", 3'd0, 1'b0);
      chk("R9", req_ready == 1'b0, "req_ready held", int'(req_ready), 0);
      rsp_ready = 1'b1;
      #0.5;
      chk("R9", req_ready == 1'b1, "req_ready on drain", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp("R9", 3'd5, 1'b0);

      // R10 register write on the same edge as a request: old bound applies
      @(negedge clk);
      req_valid = 1'b1; req_addr = 8'h44; req_write = 1'b1; port_mae = 2'b11;
      cfg_we = 1'b1; cfg_idx = IW'(7); cfg_wdata = 8'h00;
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      ml[3] = 8'h00;
      check_rsp("R10", 3'd0, 1'b0);
      req("R10", 8'h44, 1'b1, 2'b11);

      setup_s1();
      sweep();
      setup_s2();
      // R1 disabled window and single-address window
      req("R1", 8'h50, 1'b1, 2'b11);
      req("R1", 8'hA5, 1'b1, 2'b11);
      req("R1", 8'hA6, 1'b1, 2'b11);
      sweep();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule